// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Window

This block is the register window that software uses to control two IDE bus-master DMA channels. It decodes a 16-byte window on a simple byte-addressed register bus. Each channel owns an 8-byte slice. The low half of the slice holds a command byte and a status byte. The high half holds a 32-bit pointer to the channel's descriptor table. The block does not move data. The channel engines next to it read the command and pointer outputs, report activity through a busy input, and raise error and interrupt events through single-cycle set inputs.

The status byte has three kinds of bit:
- two plain read/write bits;
- a hardware-owned activity bit that software cannot change;
- error and interrupt flags that hardware sets and software clears by writing one.

The command and status bytes accept only single-byte accesses. A wider read of that half returns all ones, and a wider write there is dropped. The pointer half accepts naturally aligned byte, halfword and word accesses, and it always reads back with dword alignment.

Bus reads are combinational in the same cycle. Bus writes take effect at the clock edge that samples them.

Top module: `idebm_regs`

## Requirements
- R1: Address bit 3 selects the channel (offset 0 = channel 0, offset 8 = channel 1). Bit 2 selects the pointer half (set) or the command/status half (clear). An access to one channel never changes or reads the other channel's registers.
- R2: A byte read in the command/status half returns the command byte at offset 0 and the status byte at offset 2. Offsets 1 and 3 return 0xFF.
- R3: Access size is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. In the command/status half, a wider-than-byte read returns all ones for its width (0xFFFF or 0xFFFFFFFF), and a wider-than-byte write changes nothing.
- R4: A status write loads bits 5 and 6 from the write data. Bits 3, 4 and 7 always read 0.
- R5: Status bit 0 equals the busy input registered once. It rises one clock after busy rises and falls one clock after busy falls. A status write never changes it.
- R6: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to that bit. Writing 0 leaves them unchanged.
- R7: A one-cycle error-set or interrupt-set pulse sets its flag at the next edge. It wins over a software clear made in the same cycle.
- R8: A command write keeps only bit 0 (run, on `runOut`) and bit 3 (direction, on `toMemOut`). The other command bits read 0.
- R9: A command write that moves bit 0 from 1 to 0 raises that channel's `stopPulse` for exactly one cycle, starting at the write edge. Any other command write gives no pulse.
- R10: The pointer takes byte, halfword and word writes. The write data is right-justified and lands at the addressed bytes. A misaligned halfword or word write is ignored. Pointer bits 1:0 always read 0, and reads are right-justified to the access size.
- R11: `irqOut` of a channel is high exactly while that channel's status bit 2 is set.
- R12: After reset the command, status and pointer of both channels read 0, and no output pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset within the window |
| busSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| busWdata | input | 32 | Right-justified write data |
| busRdata | output | 32 | Right-justified read data, same cycle |
| xferBusy | input | 2 | Per channel: transfer running |
| errSet | input | 2 | Per channel: one-cycle error event |
| irqSet | input | 2 | Per channel: one-cycle interrupt event |
| runOut | output | 2 | Per channel: command run bit |
| toMemOut | output | 2 | Per channel: command direction bit |
| stopPulse | output | 2 | Per channel: one-cycle stop request |
| descPtr | output | 64 | Descriptor pointers, channel c at bits 32c+31:32c |
| irqOut | output | 2 | Per channel interrupt |

## Verification
A vector table drives several access patterns, and each one separates a different decode fault:
- byte reads at all four offsets of the command/status half, which expose a wrong byte mux or a wrong 0xFF fill;
- halfword and word accesses to that half, which show whether wide accesses are really blocked;
- aligned and misaligned writes of each size to the pointer, which show byte-lane placement and alignment masking;
- accesses to the second channel, which reveal crosstalk between channels.

Directed sequences cover the status flags:
- write-one versus write-zero on the error and interrupt flags;
- a hardware set that lands in the same cycle as a software clear;
- a status write made while busy is high and while busy is low;
- a run-to-stop command write compared with a repeated stop write, which separates a true edge pulse from a level.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
  parameter int NUM_CH = 2;
  parameter int CH_BYTES = 8;
  parameter int DATA_W = 32;
  localparam int ADDR_W = $clog2(NUM_CH * CH_BYTES);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BE_W = DATA_W / 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_CMD, RD_STAT, RD_FF, RD_ONES, RD_PTR
  } rdKind_e;

  typedef struct packed {
    logic [NUM_CH-1:0]           cmdWr;
    logic [NUM_CH-1:0]           statWr;
    logic [NUM_CH-1:0][BE_W-1:0] ptrBe;
    logic [7:0]                  byteData;
    logic [DATA_W-1:0]           laneData;
    rdKind_e                     rdKind;
    logic [CH_W-1:0]             rdCh;
    logic [1:0]                  rdOff;
    logic [DATA_W-1:0]           rdMask;
  } strobe_t;
endpackage

// File: rtl/idebm_ctrl.sv
module idebm_ctrl
  import idebm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  logic [CH_W-1:0]   chIdx;
  logic              isPtr;
  logic [1:0]        offs;
  logic              aligned;
  logic [BE_W-1:0]   widthBe;
  logic [DATA_W-1:0] sizeMask;

  always_comb begin
    chIdx = CH_W'(busAddr[ADDR_W-1:3]);
    isPtr = busAddr[2];
    offs  = busAddr[1:0];
    case (busSize)
      2'd0:    begin sizeMask = 32'h0000_00FF; widthBe = 4'b0001; end
      2'd1:    begin sizeMask = 32'h0000_FFFF; widthBe = 4'b0011; end
      default: begin sizeMask = 32'hFFFF_FFFF; widthBe = 4'b1111; end
    endcase
    aligned = (busSize == 2'd0) || (busSize == 2'd1 && !offs[0]) ||
              (busSize[1] && offs == 2'd0);
  end

  always_comb begin
    strb          = '0;
    strb.byteData = busWdata[7:0];
    strb.laneData = busWdata << {offs, 3'b000};
    strb.rdMask   = sizeMask;
    strb.rdCh     = chIdx;
    strb.rdOff    = offs;
    strb.rdKind   = RD_NONE;
    if (busSel) begin
      if (isPtr) begin
        if (busWr) begin
          if (aligned) strb.ptrBe[chIdx] = BE_W'(widthBe << offs);
        end else begin
          strb.rdKind = RD_PTR;
        end
      end else if (busSize != 2'd0) begin
        if (!busWr) strb.rdKind = RD_ONES;
      end else begin
        case (offs)
          2'd0: if (busWr) strb.cmdWr[chIdx] = 1'b1; else strb.rdKind = RD_CMD;
          2'd2: if (busWr) strb.statWr[chIdx] = 1'b1; else strb.rdKind = RD_STAT;
          default: if (!busWr) strb.rdKind = RD_FF;
        endcase
      end
    end
  end

  // R3: a wide access to the command/status half never produces a write strobe
  assert_wide_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr[2] && busSize != 2'd0) |->
      (strb.cmdWr == '0 && strb.statWr == '0));

  // R10: a pointer write strobe is only issued for an aligned access
  assert_ptr_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrBe != '0) |-> aligned);
endmodule

// File: rtl/idebm_dp.sv
module idebm_dp
  import idebm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NUM_CH-1:0]        xferBusy,
  input  logic [NUM_CH-1:0]        errSet,
  input  logic [NUM_CH-1:0]        irqSet,
  output logic [DATA_W-1:0]        busRdata,
  output logic [NUM_CH-1:0]        runOut,
  output logic [NUM_CH-1:0]        toMemOut,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH*DATA_W-1:0] descPtr,
  output logic [NUM_CH-1:0]        irqOut
);
  logic [NUM_CH-1:0]             runQ, toMemQ, activeQ, errQ, irqQ, stopQ;
  logic [NUM_CH-1:0][1:0]        userQ;
  logic [NUM_CH-1:0][DATA_W-1:0] ptrQ;
  logic [NUM_CH-1:0][7:0]        cmdByte, statByte;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        runQ[c]    <= 1'b0;
        toMemQ[c]  <= 1'b0;
        stopQ[c]   <= 1'b0;
        activeQ[c] <= 1'b0;
        errQ[c]    <= 1'b0;
        irqQ[c]    <= 1'b0;
        userQ[c]   <= 2'b00;
        ptrQ[c]    <= '0;
      end else begin
        stopQ[c]   <= 1'b0;
        activeQ[c] <= xferBusy[c];
        if (strb.cmdWr[c]) begin
          runQ[c]   <= strb.byteData[0];
          toMemQ[c] <= strb.byteData[3];
          stopQ[c]  <= runQ[c] & ~strb.byteData[0];
        end
        if (strb.statWr[c]) begin
          userQ[c] <= strb.byteData[6:5];
          errQ[c]  <= errSet[c] | (errQ[c] & ~strb.byteData[1]);
          irqQ[c]  <= irqSet[c] | (irqQ[c] & ~strb.byteData[2]);
        end else begin
          errQ[c]  <= errQ[c] | errSet[c];
          irqQ[c]  <= irqQ[c] | irqSet[c];
        end
        for (int b = 0; b < BE_W; b++) begin
          if (strb.ptrBe[c][b]) ptrQ[c][8*b +: 8] <= strb.laneData[8*b +: 8];
        end
        ptrQ[c][1:0] <= 2'b00;
      end
    end

    assign cmdByte[c]  = {4'b0000, toMemQ[c], 2'b00, runQ[c]};
    assign statByte[c] = {1'b0, userQ[c], 2'b00, irqQ[c], errQ[c], activeQ[c]};
    assign runOut[c]    = runQ[c];
    assign toMemOut[c]  = toMemQ[c];
    assign stopPulse[c] = stopQ[c];
    assign irqOut[c]    = irqQ[c];
    assign descPtr[DATA_W*c +: DATA_W] = ptrQ[c];

    // R7: hardware set events always land
    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rstN)
      errSet[c] |=> errQ[c]);
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rstN)
      irqSet[c] |=> irqQ[c]);
    // R9: a stop pulse only follows a run bit falling
    assert_stop_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
      stopQ[c] |-> ($past(runQ[c]) && !runQ[c]));
    // R5: activity bit follows the busy input one clock later
    assert_active_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(xferBusy[c]) |=> activeQ[c]);
    // R6: software writes can never set the error flag
    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.statWr[c] && !errSet[c] && !errQ[c]) |=> !errQ[c]);
  end

  always_comb begin
    case (strb.rdKind)
      RD_CMD:  busRdata = {24'h0, cmdByte[strb.rdCh]};
      RD_STAT: busRdata = {24'h0, statByte[strb.rdCh]};
      RD_FF:   busRdata = 32'h0000_00FF;
      RD_ONES: busRdata = strb.rdMask;
      RD_PTR:  busRdata = (ptrQ[strb.rdCh] >> {strb.rdOff, 3'b000}) & strb.rdMask;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/idebm_regs.sv
module idebm_regs
  import idebm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [1:0]               busSize,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [NUM_CH-1:0]        xferBusy,
  input  logic [NUM_CH-1:0]        errSet,
  input  logic [NUM_CH-1:0]        irqSet,
  output logic [NUM_CH-1:0]        runOut,
  output logic [NUM_CH-1:0]        toMemOut,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH*DATA_W-1:0] descPtr,
  output logic [NUM_CH-1:0]        irqOut
);
  strobe_t strb;

  idebm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .strb(strb)
  );

  idebm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .xferBusy(xferBusy),
    .errSet(errSet), .irqSet(irqSet), .busRdata(busRdata),
    .runOut(runOut), .toMemOut(toMemOut), .stopPulse(stopPulse),
    .descPtr(descPtr), .irqOut(irqOut)
  );

  // R11: interrupt line mirrors the interrupt flag seen through the bus
  assert_irq_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busSize == 2'd0 && busAddr[2:0] == 3'd2 && busAddr[3] == 1'b0)
      |-> (busRdata[2] == irqOut[0]));
endmodule

// File: tb/tb_idebm_regs.sv
module tb_idebm_regs;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [3:0]  busAddr;
  logic [1:0]  busSize;
  logic [31:0] busWdata, busRdata;
  logic [1:0]  xferBusy, errSet, irqSet;
  logic [1:0]  runOut, toMemOut, stopPulse, irqOut;
  logic [63:0] descPtr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idebm_regs dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .xferBusy(xferBusy), .errSet(errSet), .irqSet(irqSet), .runOut(runOut),
    .toMemOut(toMemOut), .stopPulse(stopPulse), .descPtr(descPtr), .irqOut(irqOut)
  );

  // entry: {isRead, addr, size, data/expected, reqNo}
  localparam int NV = 29;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 4'h0, 2'd0, 32'h0000_0000, 4'd12}, // R12 cmd reset
    {1'b1, 4'h2, 2'd0, 32'h0000_0000, 4'd12}, // R12 status reset
    {1'b1, 4'h1, 2'd0, 32'h0000_00FF, 4'd2},  // R2
    {1'b1, 4'h3, 2'd0, 32'h0000_00FF, 4'd2},  // R2
    {1'b0, 4'h0, 2'd0, 32'h0000_00FF, 4'd8},  // R8 write all ones
    {1'b1, 4'h0, 2'd0, 32'h0000_0009, 4'd8},  // R8 only bits 0 and 3
    {1'b1, 4'h0, 2'd1, 32'h0000_FFFF, 4'd3},  // R3 half read
    {1'b1, 4'h0, 2'd2, 32'hFFFF_FFFF, 4'd3},  // R3 word read
    {1'b0, 4'h0, 2'd1, 32'h0000_0000, 4'd3},  // R3 half write ignored
    {1'b1, 4'h0, 2'd0, 32'h0000_0009, 4'd3},
    {1'b0, 4'h2, 2'd2, 32'h0000_00FF, 4'd3},  // R3 word status write ignored
    {1'b1, 4'h2, 2'd0, 32'h0000_0000, 4'd3},
    {1'b0, 4'h2, 2'd0, 32'h0000_00FF, 4'd4},  // R4
    {1'b1, 4'h2, 2'd0, 32'h0000_0060, 4'd4},
    {1'b0, 4'hC, 2'd2, 32'h1234_5677, 4'd10}, // R10 word write
    {1'b1, 4'hC, 2'd2, 32'h1234_5674, 4'd10},
    {1'b0, 4'hD, 2'd0, 32'h0000_00AB, 4'd10}, // R10 byte write
    {1'b1, 4'hC, 2'd2, 32'h1234_AB74, 4'd10},
    {1'b0, 4'hE, 2'd1, 32'h0000_BEEF, 4'd10}, // R10 half write
    {1'b1, 4'hE, 2'd1, 32'h0000_BEEF, 4'd10},
    {1'b0, 4'hD, 2'd1, 32'h0000_0000, 4'd10}, // R10 misaligned ignored
    {1'b1, 4'hC, 2'd2, 32'hBEEF_AB74, 4'd10},
    {1'b1, 4'h4, 2'd2, 32'h0000_0000, 4'd1},  // R1 ch0 pointer untouched
    {1'b1, 4'h8, 2'd0, 32'h0000_0000, 4'd1},  // R1 ch1 cmd
    {1'b1, 4'hA, 2'd0, 32'h0000_0000, 4'd1},  // R1 ch1 status
    {1'b0, 4'h8, 2'd0, 32'h0000_0008, 4'd1},
    {1'b1, 4'h8, 2'd0, 32'h0000_0008, 4'd1},
    {1'b1, 4'h0, 2'd0, 32'h0000_0009, 4'd1},  // R1 ch0 cmd unchanged
    {1'b1, 4'hD, 2'd0, 32'h0000_00AB, 4'd10}  // R10 byte read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busSize = s; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busSize = s;
    #2 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busSel = 0; busWr = 0; busAddr = 0; busSize = 0; busWdata = 0;
    xferBusy = 0; errSet = 0; irqSet = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    check("R12 irqOut/stopPulse", {28'h0, irqOut, stopPulse}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) begin
        busRead(VEC[i][41:38], VEC[i][37:36], rd);
        checks++;
        if (rd !== VEC[i][35:4]) begin
          errors++;
          $display("FAIL R%0d vector %0d: got 0x%08h expected 0x%08h",
                   VEC[i][3:0], i, rd, VEC[i][35:4]);
        end
      end else begin
        busWrite(VEC[i][41:38], VEC[i][37:36], VEC[i][35:4]);
      end
    end
    check("R8 run/dir outputs", {30'h0, runOut[0], toMemOut[0]}, 32'h3);
    check("R10 descPtr ch1 port", descPtr[63:32], 32'hBEEF_AB74);

    // R9 stop pulse: run 1 -> 0
    busWrite(4'h0, 2'd0, 32'h0);
    check("R9 stop pulse high", {31'h0, stopPulse[0]}, 32'h1);
    @(negedge clk);
    check("R9 stop pulse one cycle", {31'h0, stopPulse[0]}, 32'h0);
    busWrite(4'h0, 2'd0, 32'h0);
    check("R9 no pulse on repeat stop", {31'h0, stopPulse[0]}, 32'h0);

    // R5 activity bit
    @(negedge clk); xferBusy[0] = 1'b1;
    busRead(4'h2, 2'd0, rd);
    check("R5 active set", rd, 32'h61);
    busWrite(4'h2, 2'd0, 32'h60);
    busRead(4'h2, 2'd0, rd);
    check("R5 write cannot clear active", rd, 32'h61);
    @(negedge clk); xferBusy[0] = 1'b0;
    busRead(4'h2, 2'd0, rd);
    check("R5 active cleared", rd, 32'h60);
    busWrite(4'h2, 2'd0, 32'h61);
    busRead(4'h2, 2'd0, rd);
    check("R5 write cannot set active", rd, 32'h60);

    // R6 write-one-to-clear, R11 interrupt output
    @(negedge clk); errSet[0] = 1'b1; irqSet[0] = 1'b1;
    @(negedge clk); errSet[0] = 1'b0; irqSet[0] = 1'b0;
    busRead(4'h2, 2'd0, rd);
    check("R6 flags set by hardware", rd, 32'h66);
    check("R11 irq high", {31'h0, irqOut[0]}, 32'h1);
    check("R11 other channel irq low", {31'h0, irqOut[1]}, 32'h0);
    busWrite(4'h2, 2'd0, 32'h62);
    busRead(4'h2, 2'd0, rd);
    check("R6 clear error only", rd, 32'h64);
    busWrite(4'h2, 2'd0, 32'h60);
    busRead(4'h2, 2'd0, rd);
    check("R6 zeros leave flags", rd, 32'h64);
    busWrite(4'h2, 2'd0, 32'h04);
    busRead(4'h2, 2'd0, rd);
    check("R6 clear irq", rd, 32'h00);
    check("R11 irq low", {31'h0, irqOut[0]}, 32'h0);

    // R7 set wins over same-cycle clear
    @(negedge clk); irqSet[0] = 1'b1;
    @(negedge clk); irqSet[0] = 1'b0;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'h2; busSize = 2'd0; busWdata = 32'h06;
    errSet[0] = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; errSet[0] = 1'b0;
    busRead(4'h2, 2'd0, rd);
    check("R7 error set beats clear", rd, 32'h02);

    // R12 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(4'hC, 2'd2, rd);
    check("R12 pointer reset", rd, 32'h0);
    busRead(4'h8, 2'd0, rd);
    check("R12 cmd reset", rd, 32'h0);
    busRead(4'h2, 2'd0, rd);
    check("R12 status reset", rd, 32'h0);
    finish();
  end
endmodule